// File: doc/BRIEF.md
# Decimating FIR Channel with Runtime Bypass

This block filters one stream of signed 16-bit samples and reduces its rate by a fixed factor. Each input sample comes with a valid strobe and an enable qualifier. When the `active` control is high, the block keeps a history of the most recent accepted samples. After every `RATE` accepted samples it forms a weighted sum of that history using signed integer coefficients given as a parameter. It then rounds the sum and emits the result as a single output sample.

When `active` is low the filter is out of the path. The output valid and data then repeat the input valid and data one clock later. The enable qualifier never goes through the filter: in both modes it is simply registered to the output. Dropping `active` also clears the sample history and the decimation phase, so each period of filtering starts from an empty window.

The weighted sum has 15 fractional bits, as the input does. It is scaled down by `2^OUT_SHIFT`, rounded to the nearest integer with exact halves going toward zero, and clamped to the signed 16-bit range.

Top module: `fir_dec_channel`

## Requirements
- R1: While `active` is low at a clock edge, `valid_out` and `data_out` after that edge equal the `valid_in` and `data_in` sampled at that edge.
- R2: After every clock edge outside reset, `enable_out` equals the `enable_in` sampled at that edge, whatever the value of `active`.
- R3: While `active` is high, a sample counts as accepted only when `valid_in` is high. `valid_out` pulses for one cycle once per `RATE` accepted samples, two clock edges after the edge that accepts the `RATE`-th sample. Cycles with `valid_in` low neither advance the count nor shift the history.
- R4: A filtered output is the sum over k = 0..TAPS-1 of `COEF[k]` times the k-th most recent accepted sample. k = 0 is the sample that completed the group, and positions with no sample since activation count as zero. The sum is scaled by 2^-OUT_SHIFT.
- R5: Scaling rounds to the nearest integer, and an exact half rounds toward zero. With OUT_SHIFT = 12, a sum of +2048 gives 0, -2048 gives 0, +6144 gives 1, and -6144 gives -1.
- R6: A scaled result above 32767 is output as 32767. A scaled result below -32768 is output as -32768.
- R7: One clock edge with `active` low clears the history and the phase count. After `active` returns high, the next output needs `RATE` new accepted samples, and earlier samples contribute nothing.
- R8: While `rst` is high, `valid_out`, `enable_out` and `data_out` are all zero after each clock edge.
- R9: While `active` is high, `data_out` keeps its previous value on every cycle in which `valid_out` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| active | input | 1 | High: filtered, decimated output; low: registered pass-through |
| valid_in | input | 1 | Input sample strobe |
| enable_in | input | 1 | Input enable qualifier, always passed through |
| data_in | input | 16 | Signed input sample, 15 fractional bits |
| valid_out | output | 1 | Output sample strobe |
| enable_out | output | 1 | Registered copy of enable_in |
| data_out | output | 16 | Signed output sample |

## Verification
Pass-through valid, pass-through data and the enable qualifier are all due one clock edge after the edge that samples them. A filtered result is due two edges after the edge that accepts the last sample of its group. The first edge updates the history and marks the group as complete; the second registers the rounded sum. The bench model advances on every rising edge and computes the values the outputs must hold after that edge, with the same two-edge delay for filtered results. The outputs are compared with the model at the following falling edge, so each check sees settled values at exactly the cycle its result is due.

// File: rtl/fir_dec_pkg.sv
package fir_dec_pkg;
  // Accumulator width: product width plus growth for summing TAPS products.
  function automatic int acc_width(input int dw, input int cw, input int taps);
    return dw + cw + ((taps > 1) ? $clog2(taps) : 1);
  endfunction

  // Phase counter width for a decimation factor.
  function automatic int phase_width(input int rate);
    return (rate > 1) ? $clog2(rate) : 1;
  endfunction
endpackage

// File: rtl/fir_dec_history.sv
module fir_dec_history
  import fir_dec_pkg::*;
#(
  parameter int DW   = 16,
  parameter int TAPS = 8,
  parameter int RATE = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 active,
  input  logic                 valid_in,
  input  logic signed [DW-1:0] data_in,
  output logic signed [DW-1:0] taps_o [TAPS],
  output logic                 fire_o
);
  localparam int PW = phase_width(RATE);

  logic signed [DW-1:0] tap_q [TAPS];
  logic [PW-1:0]        phase_q;
  logic                 last_of_group;

  assign last_of_group = (phase_q == PW'(RATE - 1));

  // Delay line: newest accepted sample at index 0, cleared while bypassed.
  always_ff @(posedge clk) begin
    if (rst || !active) begin
      for (int i = 0; i < TAPS; i++) tap_q[i] <= '0;
    end else if (valid_in) begin
      tap_q[0] <= data_in;
      for (int i = 1; i < TAPS; i++) tap_q[i] <= tap_q[i-1];
    end
  end

  // Decimation phase and group-complete flag.
  always_ff @(posedge clk) begin
    if (rst || !active) begin
      phase_q <= '0;
      fire_o  <= 1'b0;
    end else begin
      fire_o <= valid_in && last_of_group;
      if (valid_in) phase_q <= last_of_group ? '0 : phase_q + 1'b1;
    end
  end

  for (genvar g = 0; g < TAPS; g++) begin : g_out
    assign taps_o[g] = tap_q[g];
  end

  // R3: the phase never leaves 0..RATE-1
  p_phase_range_r3: assert property (@(posedge clk) disable iff (rst)
    int'(phase_q) < RATE);

  // R3: a completed group always follows an accepted sample in active mode
  p_fire_source_r3: assert property (@(posedge clk) disable iff (rst)
    fire_o |-> $past(valid_in && active));

  // R7: bypass clears the decimation state
  p_clear_r7: assert property (@(posedge clk) disable iff (rst)
    $past(!active) |-> (phase_q == '0 && !fire_o));
endmodule

// File: rtl/fir_dec_mac.sv
module fir_dec_mac
  import fir_dec_pkg::*;
#(
  parameter int DW   = 16,
  parameter int CW   = 16,
  parameter int TAPS = 8,
  parameter int AW   = acc_width(DW, CW, TAPS),
  parameter logic signed [CW-1:0] COEF [TAPS] = '{default: '0}
) (
  input  logic signed [DW-1:0] taps_i [TAPS],
  output logic signed [AW-1:0] acc_o
);
  localparam int PWID = DW + CW;

  logic signed [PWID-1:0] prod [TAPS];

  for (genvar g = 0; g < TAPS; g++) begin : g_mul
    assign prod[g] = taps_i[g] * COEF[g];
  end

  always_comb begin
    acc_o = '0;
    for (int i = 0; i < TAPS; i++) begin
      acc_o = acc_o + {{(AW-PWID){prod[i][PWID-1]}}, prod[i]};
    end
  end
endmodule

// File: rtl/fir_dec_quant.sv
module fir_dec_quant #(
  parameter int AW    = 35,
  parameter int OW    = 16,
  parameter int SHIFT = 12
) (
  input  logic signed [AW-1:0] acc_i,
  output logic signed [OW-1:0] q_o
);
  localparam logic signed [AW-1:0] HALF = AW'(1) <<< (SHIFT - 1);
  localparam logic signed [AW-1:0] MAXV = {{(AW-OW+1){1'b0}}, {(OW-1){1'b1}}};
  localparam logic signed [AW-1:0] MINV = {{(AW-OW+1){1'b1}}, {(OW-1){1'b0}}};

  always_comb begin : rnd_sat
    logic signed [AW-1:0] biased;
    logic signed [AW-1:0] scaled;
    logic signed [AW-1:0] clamped;
    // Halves go toward zero: positive sums add HALF-1, negative add HALF.
    biased = acc_i[AW-1] ? (acc_i + HALF) : (acc_i + HALF - AW'(1));
    scaled = biased >>> SHIFT;
    if (scaled > MAXV)      clamped = MAXV;
    else if (scaled < MINV) clamped = MINV;
    else                    clamped = scaled;
    q_o = OW'(clamped);
  end
endmodule

// File: rtl/fir_dec_channel.sv
module fir_dec_channel
  import fir_dec_pkg::*;
#(
  parameter int DW        = 16,
  parameter int CW        = 16,
  parameter int TAPS      = 8,
  parameter int RATE      = 4,
  parameter int OUT_SHIFT = 12,
  parameter logic signed [CW-1:0] COEF [TAPS] = '{
    16'sd2048, -16'sd3000, 16'sd4096, 16'sd6000,
    16'sd6000, 16'sd4096, -16'sd3000, 16'sd2048}
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          active,
  input  logic          valid_in,
  input  logic          enable_in,
  input  logic [DW-1:0] data_in,
  output logic          valid_out,
  output logic          enable_out,
  output logic [DW-1:0] data_out
);
  localparam int AW = acc_width(DW, CW, TAPS);

  logic signed [DW-1:0] hist [TAPS];
  logic                 fire;
  logic signed [AW-1:0] acc;
  logic signed [DW-1:0] q;

  fir_dec_history #(.DW(DW), .TAPS(TAPS), .RATE(RATE)) u_hist (
    .clk      (clk),
    .rst      (rst),
    .active   (active),
    .valid_in (valid_in),
    .data_in  (data_in),
    .taps_o   (hist),
    .fire_o   (fire)
  );

  fir_dec_mac #(.DW(DW), .CW(CW), .TAPS(TAPS), .AW(AW), .COEF(COEF)) u_mac (
    .taps_i (hist),
    .acc_o  (acc)
  );

  fir_dec_quant #(.AW(AW), .OW(DW), .SHIFT(OUT_SHIFT)) u_quant (
    .acc_i (acc),
    .q_o   (q)
  );

  // Registered output select: filtered path or raw pass-through.
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_out  <= 1'b0;
      enable_out <= 1'b0;
      data_out   <= '0;
    end else begin
      enable_out <= enable_in;
      if (active) begin
        valid_out <= fire;
        if (fire) data_out <= q;
      end else begin
        valid_out <= valid_in;
        data_out  <= data_in;
      end
    end
  end

  // R1: bypass repeats valid and data one edge later
  p_bypass_r1: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(!active)) |->
      (valid_out == $past(valid_in) && data_out == $past(data_in)));

  // R2: enable never waits on the filter
  p_enable_follow_r2: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> enable_out == $past(enable_in));

  // R5: rounding never flips the sign of the sum
  p_round_pos_r5: assert property (@(posedge clk) disable iff (rst)
    (acc >= 0) |-> (q >= 0));
  p_round_neg_r5: assert property (@(posedge clk) disable iff (rst)
    (acc < 0) |-> (q <= 0));

  // R9: filtered data holds between output strobes
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(active) && !valid_out) |-> $stable(data_out));
endmodule

// File: tb/fir_dec_channel_bench.sv
module fir_dec_channel_bench;
  localparam int TAPS  = 8;
  localparam int RATE  = 4;
  localparam int SHIFT = 12;
  localparam int BC [TAPS] = '{2048, -3000, 4096, 6000, 6000, 4096, -3000, 2048};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic active = 1'b0;
  logic valid_in = 1'b0;
  logic enable_in = 1'b0;
  logic [15:0] data_in = '0;
  logic valid_out, enable_out;
  logic [15:0] data_out;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  string cur_tag = "R4";

  always #4 clk = ~clk;

  fir_dec_channel u_fir_dec_channel (
    .clk(clk), .rst(rst), .active(active), .valid_in(valid_in),
    .enable_in(enable_in), .data_in(data_in),
    .valid_out(valid_out), .enable_out(enable_out), .data_out(data_out)
  );

  // Behavioural reference model
  longint hist [TAPS];
  int     ph;
  bit     grp_done;
  bit     armed;
  logic   e_v, e_e;
  logic [15:0] e_d;
  string  t_v, t_e, t_d;

  function automatic logic [15:0] ref_out();
    longint s, mag, r;
    s = 0;
    for (int k = 0; k < TAPS; k++) s += longint'(BC[k]) * hist[k];
    mag = (s < 0) ? -s : s;
    r = (mag + (longint'(1) << (SHIFT - 1)) - 1) >> SHIFT;
    if (s < 0) r = -r;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return 16'(r);
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      e_v = 0; e_e = 0; e_d = '0;
      t_v = "R8"; t_e = "R8"; t_d = "R8";
      for (int k = 0; k < TAPS; k++) hist[k] = 0;
      ph = 0; grp_done = 0;
    end else begin
      e_e = enable_in; t_e = "R2";
      if (active) begin
        e_v = grp_done; t_v = "R3";
        if (grp_done) begin e_d = ref_out(); t_d = cur_tag; end
        else t_d = "R9";
      end else begin
        e_v = valid_in; e_d = data_in; t_v = "R1"; t_d = "R1";
      end
      if (!active) begin
        for (int k = 0; k < TAPS; k++) hist[k] = 0;
        ph = 0; grp_done = 0;
      end else begin
        grp_done = valid_in && (ph == RATE - 1);
        if (valid_in) begin
          for (int k = TAPS - 1; k > 0; k--) hist[k] = hist[k-1];
          hist[0] = longint'($signed(data_in));
          ph = (ph == RATE - 1) ? 0 : ph + 1;
        end
      end
    end
    armed = 1;
  end

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", tag, what, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    if (armed) begin
      chk(t_v, "valid_out", valid_out, e_v);
      chk(t_e, "enable_out", enable_out, e_e);
      chk(t_d, "data_out", $signed(data_out), $signed(e_d));
    end
  end

  task automatic drive(input bit a, input bit v, input logic [15:0] d);
    @(negedge clk);
    active = a; valid_in = v; data_in = d; enable_in = 1'($urandom);
  endtask

  initial begin
    armed = 0;
    repeat (4) @(negedge clk);                  // R8 reset outputs checked
    rst = 1'b0;
    // R1, R2: bypass with random traffic
    repeat (200) drive(0, 1'($urandom), 16'($urandom));
    // R3, R4, R9: active with gaps in valid
    cur_tag = "R4";
    repeat (600) drive(1, ($urandom % 10) < 7, 16'($urandom));
    // R5: ties at exactly half (only tap 0 populated)
    cur_tag = "R5";
    foreach (BC[i]) begin end
    for (int j = 0; j < 4; j++) begin
      logic [15:0] xs [4] = '{16'd1, -16'sd1, 16'd3, -16'sd3};
      drive(0, 0, 0);
      repeat (3) drive(1, 1, 0);
      drive(1, 1, xs[j]);
      repeat (3) drive(1, 0, 0);
    end
    // R6: saturation both ways
    cur_tag = "R6";
    drive(0, 0, 0);
    repeat (12) drive(1, 1, 16'h7FFF);
    drive(1, 0, 0); drive(1, 0, 0);
    drive(0, 0, 0);
    repeat (12) drive(1, 1, 16'h8000);
    drive(1, 0, 0); drive(1, 0, 0);
    // R7: partial group, bypass, then new group
    cur_tag = "R7";
    for (int j = 0; j < 20; j++) begin
      repeat (2) drive(1, 1, 16'($urandom));
      drive(0, 0, 16'($urandom));
      repeat (6) drive(1, 1, 16'($urandom));
      drive(1, 0, 0); drive(1, 0, 0);
    end
    // R8: reset in the middle of traffic
    repeat (3) drive(1, 1, 16'($urandom));
    rst = 1'b1;
    repeat (3) drive(1, 1, 16'($urandom));
    rst = 1'b0;
    repeat (40) drive(1, 1, 16'($urandom));
    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(8 * 100000);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=0", cycles);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule